// File: doc/BRIEF.md
# Watchdog Override Lock and Expiry Router

This block holds the system control register that sits between software and a watchdog timer. It keeps a one-way override flag. While the flag is set, software may change the watchdog disable bit. Once software clears the flag, that disable bit is frozen until the next reset. The same register holds a route bit. The route bit sends each watchdog expiry either to a reset output or to an interrupt output.

Software reaches two word addresses on a simple synchronous bus. The bus has a write strobe, an address and 16 bits of write data. Reads are combinational. The watchdog counter is outside this block and signals expiry with a single-cycle pulse. That pulse comes out as a registered, one-cycle pulse on exactly one of the two outputs, or on neither output if the watchdog is disabled.

Top module: `wdt_ovr_ctl`

## Requirements
- R1: After reset the override flag (status bit 0) is 1, and a read of the status address returns 0x0001.
- R2: A status write with data bit 0 = 1 clears the override flag. A status write with data bit 0 = 0 leaves the flag unchanged.
- R3: Once cleared, the override flag stays 0 whatever is written, until the next reset.
- R4: The disable bit is bit 0 of the control address. A control write updates it only while the override flag is 1. While the flag is 0, control writes are ignored.
- R5: The route bit is status bit 1. It resets to 0 and is loaded from write data bit 1 on every status write. With route = 0, expiry pulses the reset output. With route = 1, expiry pulses the interrupt output. The two outputs are never high together.
- R6: Status bits 15:2 and control bits 15:1 always read 0, and writes to them have no effect.
- R7: The disable bit resets to 0, so the watchdog starts enabled.
- R8: While the disable bit is 1, an expiry pulse produces no pulse on either output.
- R9: An output pulse appears in the clock cycle after the expiry input is sampled high, and it lasts one cycle.
- R10: A read of any address other than the two mapped ones returns 0. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus word address |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Combinational read data |
| expire_i | input | 1 | One-cycle watchdog expiry pulse |
| wd_rst_o | output | 1 | Registered reset pulse |
| wd_irq_o | output | 1 | Registered interrupt pulse |

## Verification
Each of the three state bits can be read directly, so a flag that clears on the wrong data value, or that recovers without a reset, shows up on the next read of the status address. A disable bit that ignores the lock shows up on the next read of the control address. A wrong route or mask value does not show up until an expiry pulse occurs. It is then seen one cycle later, as a pulse on the wrong output or a missing pulse. For that reason the bench fires an expiry after every change of state.

// File: rtl/wdt_ovr_ctl.sv
`timescale 1ns/1ps
module wdt_ovr_ctl #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              expire_i,
  output logic              wd_rst_o,
  output logic              wd_irq_o
);

  logic ovr, route, dis;
  logic wr_stat, wr_ctrl;

  assign wr_stat = wr_en && (addr == STATUS_ADDR);
  assign wr_ctrl = wr_en && (addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr   <= 1'b1;
      route <= 1'b0;
      dis   <= 1'b0;
    end else begin
      if (wr_stat) begin
        route <= wdata[1];
        if (wdata[0]) ovr <= 1'b0;
      end
      if (wr_ctrl && ovr) dis <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_rst_o <= 1'b0;
      wd_irq_o <= 1'b0;
    end else begin
      wd_rst_o <= expire_i && !dis && !route;
      wd_irq_o <= expire_i && !dis && route;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == STATUS_ADDR)    rdata[1:0] = {route, ovr};
    else if (addr == CTRL_ADDR) rdata[0]   = dis;
  end

  assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr |=> !ovr);

  assert_dis_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr |=> $stable(dis));

  assert_one_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_rst_o && wd_irq_o));

  assert_route_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !dis && !route) |=> wd_rst_o);

  assert_route_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !dis && route) |=> wd_irq_o);

  assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !(wd_rst_o || wd_irq_o));

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_o || wd_irq_o) |-> $past(expire_i));

endmodule

// File: tb/test_wdt_ovr_ctl.sv
`timescale 1ns/1ps
module test_wdt_ovr_ctl;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_ST = 0, A_CT = 1, A_NONE = 5;

  logic clk = 0, rst_n = 0, wr_en = 0, expire_i = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic wd_rst_o, wd_irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit is_out; logic [15:0] val; string req; } item_t;
  item_t q[$];
  item_t cur;

  always #2.5 clk = ~clk;

  wdt_ovr_ctl #(.ADDR_W(AW), .STATUS_ADDR(A_ST), .CTRL_ADDR(A_CT)) i_wdt_ovr_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .expire_i(expire_i), .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o));

  always @(negedge clk) begin
    if (q.size() > 0) begin
      logic [15:0] act;
      cur = q.pop_front();
      act = cur.is_out ? {14'd0, wd_irq_o, wd_rst_o} : rdata;
      checks++;
      if (act !== cur.val) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", cur.req, act, cur.val);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    addr = a;
    q.push_back('{1'b0, exp, req});
    step();
  endtask

  // exp: bit0 = reset output, bit1 = interrupt output
  task automatic fire(input logic [1:0] exp, input string req);
    expire_i = 1;
    step();
    expire_i = 0;
    q.push_back('{1'b1, {14'd0, exp}, req});
    step();
    q.push_back('{1'b1, 16'd0, {req, " R9 width"}});
    step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    step();
  endtask

  initial begin
    do_reset();
    rd(A_ST, 16'h0001, "R1 status after reset");
    rd(A_CT, 16'h0000, "R7 disable after reset");
    fire(2'b01, "R5 route0 to reset");
    wr(A_CT, 16'h0001);
    rd(A_CT, 16'h0001, "R4 disable writable while unlocked");
    fire(2'b00, "R8 masked while disabled");
    wr(A_CT, 16'hFFFE);
    rd(A_CT, 16'h0000, "R6 control reserved ignored");
    wr(A_ST, 16'h0002);
    rd(A_ST, 16'h0003, "R2 zero write keeps flag");
    fire(2'b10, "R5 route1 to interrupt");
    wr(A_ST, 16'hFFFE);
    rd(A_ST, 16'h0003, "R6 status reserved ignored");
    wr(A_NONE, 16'hFFFF);
    rd(A_NONE, 16'h0000, "R10 unmapped read");
    rd(A_ST, 16'h0003, "R10 unmapped write no effect");
    rd(A_CT, 16'h0000, "R10 unmapped write no effect on control");
    wr(A_ST, 16'h0001);
    rd(A_ST, 16'h0000, "R2 one write clears flag");
    fire(2'b01, "R5 route back to reset");
    wr(A_ST, 16'h0000);
    wr(A_ST, 16'h0002);
    rd(A_ST, 16'h0002, "R3 flag stays cleared");
    wr(A_CT, 16'h0001);
    rd(A_CT, 16'h0000, "R4 disable locked");
    fire(2'b10, "R4 locked disable leaves expiry live");
    do_reset();
    rd(A_ST, 16'h0001, "R1 flag restored by reset");
    wr(A_CT, 16'h0001);
    rd(A_CT, 16'h0001, "R4 unlocked again after reset");
    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule